// File: doc/BRIEF.md
# Cache-Block Zeroing Engine

This block carries out the zero-a-cache-block operation of a processor's memory pipeline. A request brings a virtual address together with two verdicts that other logic has already reached: whether block zeroing is enabled for the current privilege context, and whether a store to the whole block is permitted. The engine clears the low address bits to find the start of the block that contains the address. If both verdicts are favourable, it writes zeros over every word of that block through a word-wide memory write port.

If either verdict is unfavourable, the engine writes nothing and reports the matching exception alongside its completion pulse. An address that is disabled is reported as such even when the permission check would also have failed. The block size and word size are parameters, and both must be powers of two. A check at elaboration rejects an illegal combination. The engine handles one operation at a time and ignores new requests until it has pulsed completion.

Top module: `cbz_engine`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_valid`, `done`, `exc_disabled` and `exc_access` are all 0.
- R2: The first write beat targets `req_vaddr & ~(BLOCK_BYTES-1)`, where the address is the one captured when the request was accepted in the idle state.
- R3: A permitted operation issues exactly BLOCK_BYTES/WORD_BYTES beats. The beats are in ascending address order, one WORD_BYTES step apart. Each beat has `mem_wdata` all zero and every bit of `mem_strb` set, so after the operation every byte of the block reads zero and the words on either side of the block are unchanged.
- R4: A beat that is presented while `mem_ready` is 0 stays presented with the same address in the next cycle. The beat advances only on a cycle where `mem_valid` and `mem_ready` are both 1.
- R5: A request with `req_zero_en` = 0 completes with `exc_disabled` = 1 and `exc_access` = 0, whatever the value of `req_store_ok`. No beat is issued.
- R6: A request with `req_zero_en` = 1 and `req_store_ok` = 0 completes with `exc_access` = 1 and `exc_disabled` = 0. No beat is issued and memory is left unchanged.
- R7: `done` is high for exactly one cycle per operation. The exception outputs are valid only in that cycle.
  - For a faulting request, `done` is high in the second cycle after the acceptance edge.
  - For a permitted request, `done` is high in the cycle after the edge that accepts the last beat.
- R8: A request presented while an operation is in progress, including the cycle in which `done` is high, is ignored and has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted only when idle |
| req_vaddr | input | ADDR_W | Any address inside the target block |
| req_zero_en | input | 1 | 1 = block zeroing is enabled for this context |
| req_store_ok | input | 1 | 1 = a store to the whole block is permitted |
| mem_valid | output | 1 | Write beat present |
| mem_addr | output | ADDR_W | Byte address of the beat (word aligned) |
| mem_wdata | output | 8*WORD_BYTES | Write data (always zero) |
| mem_strb | output | WORD_BYTES | Byte strobes (all set) |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| done | output | 1 | One-cycle completion pulse |
| exc_disabled | output | 1 | With done: zeroing was disabled |
| exc_access | output | 1 | With done: store permission was denied |

## Verification
The hardest situation to reach from the ports combines a stalled beat in the middle of a block with a new request that arrives while the engine is busy. The engine must keep its captured base address and must not restart when the stray request lines up with the completion pulse. The bench reaches this case in two ways. It drives `mem_ready` from random and alternating patterns. It also keeps `req_valid` asserted, with a changing address and changing flags, through the whole operation up to and including the `done` cycle. Memory contents around every block are preloaded with non-zero words, so a fault that wrote anything, or a beat that strayed outside the block, shows up in the memory image.

// File: rtl/cbz_engine.sv
module cbz_engine #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic                    req_zero_en,
  input  logic                    req_store_ok,
  output logic                    mem_valid,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*WORD_BYTES-1:0] mem_wdata,
  output logic [WORD_BYTES-1:0]   mem_strb,
  input  logic                    mem_ready,
  output logic                    done,
  output logic                    exc_disabled,
  output logic                    exc_access
);
  localparam int BEATS  = BLOCK_BYTES / WORD_BYTES;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int WSH    = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BLOCK_BYTES - 1);

  if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0
      || BLOCK_BYTES < WORD_BYTES) begin : g_bad_size
    $error("cbz_engine: BLOCK_BYTES and WORD_BYTES must be powers of two, BLOCK_BYTES >= WORD_BYTES");
  end

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WRITE, S_DONE} st_t;

  st_t               state;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic              en_q, ok_q, exd_q, exa_q;
  logic              last_beat;

  assign last_beat = (beat == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base  <= '0;
      beat  <= '0;
      en_q  <= 1'b0;
      ok_q  <= 1'b0;
      exd_q <= 1'b0;
      exa_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          base  <= req_vaddr & ~LOW_MASK;
          en_q  <= req_zero_en;
          ok_q  <= req_store_ok;
          state <= S_CHECK;
        end
        S_CHECK: begin
          beat <= '0;
          if (!en_q) begin
            exd_q <= 1'b1;
            state <= S_DONE;
          end else if (!ok_q) begin
            exa_q <= 1'b1;
            state <= S_DONE;
          end else begin
            state <= S_WRITE;
          end
        end
        S_WRITE: if (mem_ready) begin
          if (last_beat) state <= S_DONE;
          else           beat  <= beat + 1'b1;
        end
        default: begin
          exd_q <= 1'b0;
          exa_q <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_valid    = (state == S_WRITE);
  assign mem_addr     = base | (ADDR_W'(beat) << WSH);
  assign mem_wdata    = '0;
  assign mem_strb     = '1;
  assign done         = (state == S_DONE);
  assign exc_disabled = exd_q;
  assign exc_access   = exa_q;
endmodule

// File: rtl/cbz_engine_chk.sv
module cbz_engine_chk #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              exc_disabled,
  input logic              exc_access
);
  localparam int BEATS = BLOCK_BYTES / WORD_BYTES;
  localparam logic [ADDR_W-1:0] BLK_M    = ADDR_W'(BLOCK_BYTES - 1);
  localparam logic [ADDR_W-1:0] WORD_M   = ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(BLOCK_BYTES - WORD_BYTES);

  logic [15:0] hs_cnt;
  logic        exc_any;
  assign exc_any = exc_disabled | exc_access;

  always_ff @(posedge clk) begin
    if (!rst_n || done) hs_cnt <= '0;
    else if (mem_valid && mem_ready) hs_cnt <= hs_cnt + 1'b1;
  end

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && ((mem_addr & BLK_M) != LAST_OFF)
    |=> mem_valid && (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

  a_r3_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
    done && !exc_any |-> hs_cnt == 16'(BEATS));

  a_r6_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    exc_any |-> hs_cnt == 16'd0);

  a_r5_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_disabled && exc_access));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_exc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    exc_any |-> done);

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr & WORD_M) == '0);

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && done));
endmodule

bind cbz_engine cbz_engine_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (.*);

// File: tb/cbz_engine_test.sv
module cbz_engine_test;
  localparam int AW = 32;
  localparam int WB = 4;
  localparam int BB = 64;
  localparam int NB = BB / WB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_vaddr = '0;
  logic          req_zero_en = 1'b0;
  logic          req_store_ok = 1'b0;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [3:0]    mem_strb;
  logic          mem_ready = 1'b1;
  logic          done, exc_disabled, exc_access;

  cbz_engine #(.ADDR_W(AW), .WORD_BYTES(WB), .BLOCK_BYTES(BB)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int rdy_mode = 0;
  int hs_cnt = 0;
  logic [31:0] ram [int];

  int          m_state = 0;
  logic [AW-1:0] m_base = '0;
  int          m_beat = 0;
  bit          m_en = 0, m_ok = 0, m_exd = 0, m_exa = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return (a ^ 32'hA5C3_0000) | 32'h1;
  endfunction

  // reference model and memory image, advanced at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (mem_valid && mem_ready) begin
      for (int b = 0; b < WB; b++)
        if (mem_strb[b]) ram[int'(mem_addr)][8*b +: 8] = mem_wdata[8*b +: 8];
      hs_cnt++;
    end
    if (!rst_n) begin
      m_state = 0; m_exd = 0; m_exa = 0; m_beat = 0;
    end else begin
      case (m_state)
        0: if (req_valid) begin
             m_base = req_vaddr & ~AW'(BB - 1);
             m_en = req_zero_en; m_ok = req_store_ok; m_state = 1;
           end
        1: begin
             m_beat = 0;
             if (!m_en)      begin m_exd = 1; m_state = 3; end
             else if (!m_ok) begin m_exa = 1; m_state = 3; end
             else m_state = 2;
           end
        2: if (mem_ready) begin
             if (m_beat == NB - 1) m_state = 3;
             else m_beat++;
           end
        default: begin m_exd = 0; m_exa = 0; m_state = 0; end
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_valid == 0 && done == 0 && exc_disabled == 0 && exc_access == 0,
          "R1", "outputs in reset", {mem_valid, done, exc_disabled, exc_access}, 0);
    end else begin
      chk(done == (m_state == 3), "R7", "done", done, m_state == 3);
      chk(exc_disabled == (m_state == 3 && m_exd), "R5", "exc_disabled", exc_disabled, m_exd);
      chk(exc_access == (m_state == 3 && m_exa), "R6", "exc_access", exc_access, m_exa);
      chk(mem_valid == (m_state == 2), "R4", "mem_valid", mem_valid, m_state == 2);
      if (mem_valid && m_state == 2) begin
        chk(mem_addr == m_base + AW'(m_beat * WB), m_beat == 0 ? "R2" : "R3",
            "mem_addr", mem_addr, m_base + AW'(m_beat * WB));
        chk(mem_wdata == 0 && mem_strb == 4'hF, "R3", "data/strobe",
            {mem_wdata[27:0], mem_strb}, 32'hF);
      end
    end
    case (rdy_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= ~mem_ready;
      default: mem_ready <= 1'($urandom_range(0, 1));
    endcase
  end

  task automatic fill(input logic [AW-1:0] base);
    for (int w = -1; w <= NB; w++) ram[int'(base) + w*WB] = pat(base + AW'(w*WB));
  endtask

  task automatic verify_mem(input logic [AW-1:0] base, input bit zeroed, input string req);
    for (int w = 0; w < NB; w++)
      chk(ram[int'(base) + w*WB] == (zeroed ? 32'h0 : pat(base + AW'(w*WB))), req,
          "block word", ram[int'(base) + w*WB], zeroed ? 32'h0 : pat(base + AW'(w*WB)));
    chk(ram[int'(base) - WB] == pat(base - AW'(WB)), "R3", "word below block",
        ram[int'(base) - WB], pat(base - AW'(WB)));
    chk(ram[int'(base) + BB] == pat(base + AW'(BB)), "R3", "word above block",
        ram[int'(base) + BB], pat(base + AW'(BB)));
  endtask

  task automatic run_op(input logic [AW-1:0] addr, input bit en, input bit ok,
                        input bit hold, input string req);
    logic [AW-1:0] base;
    int waited;
    base = addr & ~AW'(BB - 1);
    fill(base);
    @(negedge clk);
    hs_cnt = 0;
    req_valid = 1; req_vaddr = addr; req_zero_en = en; req_store_ok = ok;
    @(negedge clk);
    waited = 1;
    if (!hold) req_valid = 0;
    while (!done && waited < 2000) begin
      if (hold) begin
        req_vaddr = req_vaddr + 32'h100; req_zero_en = ~req_zero_en;
        req_store_ok = ~req_store_ok;
      end
      @(negedge clk);
      waited++;
    end
    chk(done == 1, req, "completion seen", done, 1);
    if (!(en && ok)) chk(waited == 2, "R7", "fault latency", waited, 2);
    req_valid = 0;
    @(negedge clk);
    chk(done == 0, "R7", "done single cycle", done, 0);
    chk(hs_cnt == ((en && ok) ? NB : 0), req, "beat count", hs_cnt, (en && ok) ? NB : 0);
    verify_mem(base, en && ok, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_valid == 0 && done == 0, "R1", "idle after reset", {mem_valid, done}, 0);

    rdy_mode = 0; run_op(32'h0000_1000, 1, 1, 0, "R3");
    rdy_mode = 1; run_op(32'h0000_2037, 1, 1, 0, "R2");
    rdy_mode = 2; run_op(32'h0000_3FFC, 1, 1, 0, "R4");
    rdy_mode = 0; run_op(32'h0000_4010, 0, 0, 0, "R5");
    rdy_mode = 2; run_op(32'h0000_5004, 0, 1, 0, "R5");
    rdy_mode = 1; run_op(32'h0000_6020, 1, 0, 0, "R6");
    rdy_mode = 2; run_op(32'h0000_7033, 1, 1, 1, "R8");
    rdy_mode = 0; run_op(32'h0000_8008, 1, 0, 1, "R8");
    for (int i = 0; i < 20; i++) begin
      rdy_mode = i % 3;
      run_op(32'h0001_0000 + 32'(i * 256) + 32'($urandom_range(0, 63)),
             1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
             1'(i % 2), "R3");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule